// File: doc/BRIEF.md
# Tile Memory Load/Store Controller

This block owns the on-chip buffer that holds depth and color for one square screen tile of 32 by 32 pixels. While a tile is open it takes depth-tested fragment writes. Each fragment carries a pixel position inside the tile, a depth and a color. It reads the stored depth, compares, and on a pass rewrites both depth and color, all inside the buffer. External memory sees no per-fragment traffic. It sees at most one block read per tile and exactly one block write per tile.

A tile is opened with a start pulse that picks one of two ways to fill the buffer. In the first, every entry is set to the clear depth and clear color with no external read. In the second, the tile's previous contents are read in from external memory. When the tile ends, or a framebuffer switch forces a flush, the whole tile is written out as one burst in row-major order. The write addresses come from the tile position, a frame base address and the frame stride. A single-cycle done pulse marks the end of the burst.

The external port is a request/acknowledge bus that can read and write. Read data returns in order with its own valid strobe.

Top module: `tile_mem_ctrl`

## Requirements
- R1: After reset, frag_ready, mem_req and store_done are all low.
- R2: A tile start with tile_keep low issues no external read and sets every entry to the clear depth (default all ones) and clear color (default zero).
- R3: A tile start with tile_keep high reads all 1024 words of the tile in row-major order, and the buffer takes the returned words as its initial contents.
- R4: A fragment whose depth is strictly less than the stored depth replaces that entry's depth and color. A fragment with an equal or greater depth leaves the entry unchanged.
- R5: Fragments accepted on consecutive cycles at the same pixel are each compared against the depth left by the fragments before them.
- R6: A store burst writes 1024 words. Word k goes to frame_base + (tile_y*32 + k/32)*frame_stride + tile_x*32 + k%32. The word data is {depth, color}, with depth in the upper DW bits.
- R7: frag_ready is high only while a tile is open and its buffer is initialized, and never while a burst request is on the bus.
- R8: store_done is a one-cycle pulse in the cycle right after the edge that accepts the last word of a store burst.
- R9: A flush while the tile is being cleared or loaded stores the tile as soon as initialization completes, with no fragment accepted in between. A flush with no tile open causes no memory traffic.
- R10: While mem_req is high and mem_ack is low, mem_addr, mem_we and (for writes) mem_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tile_start | input | 1 | Opens a tile (taken only when no tile is open) |
| tile_keep | input | 1 | 1: load previous contents; 0: clear |
| tile_x | input | TW | Tile column index in the frame |
| tile_y | input | TW | Tile row index in the frame |
| frame_base | input | AW | Word address of frame pixel (0,0) |
| frame_stride | input | SW | Frame row pitch in words |
| tile_end | input | 1 | Closes the open tile and starts its store |
| flush | input | 1 | Framebuffer switch: store any open tile |
| frag_valid | input | 1 | Fragment present |
| frag_ready | output | 1 | Fragment accepted when high with frag_valid |
| frag_px | input | log2(TILE) | Pixel column inside the tile |
| frag_py | input | log2(TILE) | Pixel row inside the tile |
| frag_depth | input | DW | Fragment depth |
| frag_color | input | CW | Fragment color |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW+CW | Write data {depth, color} |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid (in request order) |
| mem_rdata | input | DW+CW | Read data |
| store_done | output | 1 | Pulse after the last store word is accepted |

## Verification
The depth test is tried with several fragment patterns. Isolated writes at a pixel separate strict less-than from less-or-equal. A depth equal to the all-ones clear value must be rejected. Same-pixel fragments sent on back-to-back cycles with falling, rising and repeated depths show whether the read-modify-write forwards the newest depth. Dense random fragments in a small band of rows cause many collisions, which are checked against a bench model. Tiles opened by clearing and by loading are compared, the loaded ones against a position-dependent pattern, and each is written out under random acknowledge and read-return gaps. A flush during clear, a flush during load and a flush with no tile open show whether pending contents are stored at the right point.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_LOAD,
    ST_ACTIVE,
    ST_DRAIN,
    ST_STORE
  } tmc_state_e;
endpackage

// File: rtl/tmc_ram.sv
module tmc_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 56,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tmc_zpipe.sv
module tmc_zpipe #(
  parameter int IW = 10,
  parameter int DW = 24,
  parameter int CW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_v,
  input  logic [IW-1:0]    in_idx,
  input  logic [DW-1:0]    in_depth,
  input  logic [CW-1:0]    in_color,
  input  logic [DW-1:0]    mem_depth,
  output logic             wr_en,
  output logic [IW-1:0]    wr_idx,
  output logic [DW+CW-1:0] wr_word
);
  // stage 1: fragment waiting for its stored depth
  logic          s1_v;
  logic [IW-1:0] s1_idx;
  logic [DW-1:0] s1_d;
  logic [CW-1:0] s1_c;
  // last write, which the buffer read of the next fragment could not see
  logic          fw_v;
  logic [IW-1:0] fw_idx;
  logic [DW-1:0] fw_d;
  logic [DW-1:0] ref_d;

  always_comb begin
    ref_d   = (fw_v && fw_idx == s1_idx) ? fw_d : mem_depth;
    wr_en   = s1_v && (s1_d < ref_d);
    wr_idx  = s1_idx;
    wr_word = {s1_d, s1_c};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      fw_v <= 1'b0;
    end else begin
      s1_v <= in_v;
      fw_v <= wr_en;
    end
    s1_idx <= in_idx;
    s1_d   <= in_depth;
    s1_c   <= in_color;
    fw_idx <= s1_idx;
    fw_d   <= s1_d;
  end
endmodule

// File: rtl/tile_mem_ctrl.sv
module tile_mem_ctrl
  import tmc_pkg::*;
#(
  parameter int TILE = 32,
  parameter int DW   = 24,
  parameter int CW   = 32,
  parameter int AW   = 32,
  parameter int TW   = 8,
  parameter int SW   = 16,
  parameter logic [DW-1:0] CLR_DEPTH = '1,
  parameter logic [CW-1:0] CLR_COLOR = '0,
  localparam int PW = $clog2(TILE),
  localparam int WW = DW + CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tile_start,
  input  logic          tile_keep,
  input  logic [TW-1:0] tile_x,
  input  logic [TW-1:0] tile_y,
  input  logic [AW-1:0] frame_base,
  input  logic [SW-1:0] frame_stride,
  input  logic          tile_end,
  input  logic          flush,
  input  logic          frag_valid,
  output logic          frag_ready,
  input  logic [PW-1:0] frag_px,
  input  logic [PW-1:0] frag_py,
  input  logic [DW-1:0] frag_depth,
  input  logic [CW-1:0] frag_color,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [WW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_rvalid,
  input  logic [WW-1:0] mem_rdata,
  output logic          store_done
);
  localparam int N  = TILE * TILE;
  localparam int IW = $clog2(N);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  tmc_state_e    state;
  logic [TW-1:0] t_x, t_y;
  logic [AW-1:0] t_base;
  logic [SW-1:0] t_stride;
  logic          flush_pend, launched;
  logic [IW-1:0] xidx, ridx;
  logic          req_q, we_q, done_q;
  logic [AW-1:0] addr_q;

  logic          r_we;
  logic [IW-1:0] r_waddr, r_raddr;
  logic [WW-1:0] r_wdata, r_q;
  logic          z_we;
  logic [IW-1:0] z_idx;
  logic [WW-1:0] z_word;
  logic          frag_fire, init_last, go_store;
  logic [IW-1:0] frag_idx;

  function automatic logic [AW-1:0] pix_addr(input logic [IW-1:0] i);
    logic [AW-1:0] row, col;
    row = AW'(t_y) * AW'(TILE) + AW'(i[IW-1:PW]);
    col = AW'(t_x) * AW'(TILE) + AW'(i[PW-1:0]);
    return t_base + row * AW'(t_stride) + col;
  endfunction

  assign frag_ready = (state == ST_ACTIVE);
  assign frag_fire  = frag_valid && frag_ready;
  assign frag_idx   = {frag_py, frag_px};
  assign mem_req    = req_q;
  assign mem_we     = we_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = r_q;
  assign store_done = done_q;

  // store reads one word ahead so r_q always matches the word on the bus
  always_comb begin
    if (state == ST_STORE) r_raddr = (req_q && mem_ack) ? xidx + 1'b1 : xidx;
    else                   r_raddr = frag_idx;
  end

  always_comb begin
    case (state)
      ST_CLEAR: begin r_we = 1'b1;       r_waddr = ridx;  r_wdata = {CLR_DEPTH, CLR_COLOR}; end
      ST_LOAD:  begin r_we = mem_rvalid; r_waddr = ridx;  r_wdata = mem_rdata; end
      default:  begin r_we = z_we;       r_waddr = z_idx; r_wdata = z_word; end
    endcase
  end

  assign init_last = (ridx == LAST) && (state == ST_CLEAR || mem_rvalid);
  assign go_store  = flush_pend || flush;

  tmc_ram #(.DEPTH(N), .WIDTH(WW)) u_ram (
    .clk(clk), .we(r_we), .waddr(r_waddr), .wdata(r_wdata),
    .raddr(r_raddr), .rdata(r_q)
  );

  tmc_zpipe #(.IW(IW), .DW(DW), .CW(CW)) u_zpipe (
    .clk(clk), .rst(rst), .in_v(frag_fire), .in_idx(frag_idx),
    .in_depth(frag_depth), .in_color(frag_color), .mem_depth(r_q[WW-1:CW]),
    .wr_en(z_we), .wr_idx(z_idx), .wr_word(z_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      req_q      <= 1'b0;
      we_q       <= 1'b0;
      done_q     <= 1'b0;
      flush_pend <= 1'b0;
      launched   <= 1'b0;
      xidx       <= '0;
      ridx       <= '0;
      addr_q     <= '0;
      t_x        <= '0;
      t_y        <= '0;
      t_base     <= '0;
      t_stride   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (tile_start) begin
          t_x        <= tile_x;
          t_y        <= tile_y;
          t_base     <= frame_base;
          t_stride   <= frame_stride;
          ridx       <= '0;
          xidx       <= '0;
          launched   <= 1'b0;
          flush_pend <= 1'b0;
          state      <= tile_keep ? ST_LOAD : ST_CLEAR;
        end
        ST_CLEAR, ST_LOAD: begin
          if (flush) flush_pend <= 1'b1;
          if (state == ST_LOAD) begin
            if (!launched) begin
              launched <= 1'b1;
              req_q    <= 1'b1;
              addr_q   <= pix_addr(xidx);
            end else if (req_q && mem_ack) begin
              if (xidx == LAST) req_q <= 1'b0;
              else begin
                xidx   <= xidx + 1'b1;
                addr_q <= pix_addr(xidx + 1'b1);
              end
            end
          end
          if (state == ST_CLEAR || mem_rvalid) ridx <= ridx + 1'b1;
          if (init_last) state <= go_store ? ST_DRAIN : ST_ACTIVE;
        end
        ST_ACTIVE: if (tile_end || flush) state <= ST_DRAIN;
        ST_DRAIN: begin
          xidx       <= '0;
          launched   <= 1'b0;
          flush_pend <= 1'b0;
          state      <= ST_STORE;
        end
        ST_STORE: begin
          if (!launched) begin
            launched <= 1'b1;
            req_q    <= 1'b1;
            we_q     <= 1'b1;
            addr_q   <= pix_addr(xidx);
          end else if (req_q && mem_ack) begin
            if (xidx == LAST) begin
              req_q  <= 1'b0;
              we_q   <= 1'b0;
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              xidx   <= xidx + 1'b1;
              addr_q <= pix_addr(xidx + 1'b1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tile_mem_ctrl_chk.sv
module tile_mem_ctrl_chk #(
  parameter int TILE = 32,
  parameter int AW   = 32,
  parameter int WW   = 56
) (
  input logic          clk,
  input logic          rst,
  input logic          frag_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [WW-1:0] mem_wdata,
  input logic          store_done
);
  localparam int N  = TILE * TILE;
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] wr_cnt;

  always_ff @(posedge clk) begin
    if (rst || store_done) wr_cnt <= '0;
    else if (mem_req && mem_we && mem_ack) wr_cnt <= wr_cnt + 1'b1;
  end

  // R7
  ready_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
    frag_ready |-> !mem_req);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R10
  wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata));

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    store_done |-> ($past(mem_req && mem_we && mem_ack) && wr_cnt == CW'(N)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    store_done |=> !store_done);
endmodule

bind tile_mem_ctrl tile_mem_ctrl_chk #(.TILE(TILE), .AW(AW), .WW(DW + CW)) u_chk (
  .clk(clk), .rst(rst), .frag_ready(frag_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .store_done(store_done)
);

// File: tb/tile_mem_ctrl_tb.sv
module tile_mem_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int TILE = 32, N = TILE * TILE, PW = 5;
  localparam int DW = 24, CW = 32, AW = 32, WW = DW + CW, TW = 8, SW = 16;
  localparam logic [DW-1:0] CLR_D = '1;
  localparam logic [CW-1:0] CLR_C = '0;

  logic clk = 0, rst = 1;
  logic tile_start = 0, tile_keep = 0, tile_end = 0, flush = 0;
  logic [TW-1:0] tile_x = 0, tile_y = 0;
  logic [AW-1:0] frame_base = 32'h1000;
  logic [SW-1:0] frame_stride = 16'd64;
  logic frag_valid = 0, frag_ready;
  logic [PW-1:0] frag_px = 0, frag_py = 0;
  logic [DW-1:0] frag_depth = 0;
  logic [CW-1:0] frag_color = 0;
  logic mem_req, mem_we, mem_ack = 0, mem_rvalid = 0, store_done;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_wdata, mem_rdata = 0;

  tile_mem_ctrl u_dut (.*);

  int n_chk = 0, n_bad = 0;
  logic [WW-1:0] ext [int];
  logic [WW-1:0] rdq [$];
  logic [DW-1:0] exp_d [N];
  logic [CW-1:0] exp_c [N];
  int cur_tx = 0, cur_ty = 0;
  int rd_acc = 0, wr_acc = 0, rd_bad = 0, wr_bad = 0, hold_bad = 0;
  int ready_bus_bad = 0, ready_cycles = 0, tot_req = 0;
  bit last_flag = 0, p_req = 0, p_ack = 0, p_we = 0;
  logic [AW-1:0] p_addr = 0;
  logic [WW-1:0] p_wdata = 0;

  function automatic logic [AW-1:0] exp_addr(int k);
    return frame_base + AW'((cur_ty * TILE + k / TILE) * int'(frame_stride) + cur_tx * TILE + k % TILE);
  endfunction

  function automatic logic [WW-1:0] ext_rd(logic [AW-1:0] a);
    if (ext.exists(int'(a))) return ext[int'(a)];
    return {DW'(a * 7 + 3), CW'(a ^ 32'h5a5a0000)};
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial forever #(CLK_P / 2) clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "ALL", "watchdog expired", 0, 1);
    report();
  end

  // memory model and bus monitor, acting at falling edges
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (p_req && !p_ack && !(mem_req && mem_addr == p_addr && mem_we == p_we &&
          (!p_we || mem_wdata == p_wdata))) hold_bad++;
      if (frag_ready && mem_req) ready_bus_bad++;
      if (frag_ready) ready_cycles++;
      if (mem_req) tot_req++;
      if (last_flag) check(store_done === 1'b1, "R8", "done after last word", store_done, 1);
      else if (store_done) check(0, "R8", "done not after last word", 1, 0);
      last_flag = 0;
      if (rdq.size() > 0 && ($urandom % 3) != 0) begin
        mem_rvalid = 1;
        mem_rdata = rdq.pop_front();
      end else mem_rvalid = 0;
      mem_ack = ($urandom % 4) != 0;
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          if (mem_addr != exp_addr(wr_acc)) wr_bad++;
          ext[int'(mem_addr)] = mem_wdata;
          wr_acc++;
          if (wr_acc == N) last_flag = 1;
        end else begin
          if (mem_addr != exp_addr(rd_acc)) rd_bad++;
          rdq.push_back(ext_rd(mem_addr));
          rd_acc++;
        end
      end
      p_req = mem_req; p_ack = mem_ack; p_we = mem_we;
      p_addr = mem_addr; p_wdata = mem_wdata;
    end
  end

  task automatic do_start(int tx, int ty, bit keep);
    cur_tx = tx; cur_ty = ty; wr_acc = 0; rd_acc = 0; rd_bad = 0; wr_bad = 0;
    for (int k = 0; k < N; k++) begin
      logic [WW-1:0] w;
      w = keep ? ext_rd(exp_addr(k)) : {CLR_D, CLR_C};
      exp_d[k] = w[WW-1:CW];
      exp_c[k] = w[CW-1:0];
    end
    tile_x = TW'(tx); tile_y = TW'(ty); tile_keep = keep; tile_start = 1;
    @(negedge clk);
    tile_start = 0;
  endtask

  task automatic send(int px, int py, logic [DW-1:0] d, logic [CW-1:0] c);
    int idx;
    frag_px = PW'(px); frag_py = PW'(py); frag_depth = d; frag_color = c; frag_valid = 1;
    forever begin
      bit acc;
      acc = frag_ready;
      @(negedge clk);
      if (acc) break;
    end
    frag_valid = 0;
    idx = py * TILE + px;
    if (d < exp_d[idx]) begin exp_d[idx] = d; exp_c[idx] = c; end
  endtask

  task automatic wait_store();
    while (wr_acc < N) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic close_tile(bit by_flush);
    if (by_flush) flush = 1; else tile_end = 1;
    @(negedge clk);
    flush = 0; tile_end = 0;
    wait_store();
  endtask

  task automatic cmp_tile(string req);
    int bad;
    logic [WW-1:0] a, e;
    bad = 0; a = 0; e = 0;
    for (int k = 0; k < N; k++) begin
      if (ext_rd(exp_addr(k)) !== {exp_d[k], exp_c[k]}) begin
        if (bad == 0) begin a = ext_rd(exp_addr(k)); e = {exp_d[k], exp_c[k]}; end
        bad++;
      end
    end
    check(bad == 0, req, "stored tile contents", a, e);
    check(wr_bad == 0, "R6", "store address order", wr_bad, 0);
    check(wr_acc == N, "R6", "store word count", wr_acc, N);
  endtask

  task automatic rand_frags(int cnt);
    for (int i = 0; i < cnt; i++)
      send($urandom % TILE, 8 + $urandom % 4, DW'($urandom), $urandom);
  endtask

  initial begin
    int rc, tr;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(frag_ready === 0, "R1", "frag_ready after reset", frag_ready, 0);
    check(mem_req === 0, "R1", "mem_req after reset", mem_req, 0);
    check(store_done === 0, "R1", "store_done after reset", store_done, 0);

    // R9: flush with no open tile
    tr = tot_req;
    flush = 1; @(negedge clk); flush = 0;
    repeat (20) @(negedge clk);
    check(tot_req == tr, "R9", "bus traffic on idle flush", tot_req - tr, 0);

    // tile (0,0) cleared
    do_start(0, 0, 0);
    check(frag_ready === 0, "R7", "ready during clear", frag_ready, 0);
    while (!frag_ready) @(negedge clk);
    check(rd_acc == 0, "R2", "reads on clear start", rd_acc, 0);
    send(0, 0, 24'd100, 32'hA0); // R5 back-to-back at pixel (0,0)
    send(0, 0, 24'd90,  32'hA1);
    send(0, 0, 24'd95,  32'hA2);
    send(0, 0, 24'd90,  32'hA3);
    send(31, 31, CLR_D, 32'hB0);  // R4 equal to clear depth
    send(5, 3, 24'd50, 32'hC0);   // R4
    send(1, 1, 24'd7, 32'h0);
    send(5, 3, 24'd50, 32'hC1);
    send(1, 1, 24'd7, 32'h0);
    send(5, 3, 24'd60, 32'hC2);
    send(2, 0, 24'd300, 32'hD0);  // R5 rising then falling
    send(2, 0, 24'd400, 32'hD1);
    send(2, 0, 24'd200, 32'hD2);
    rand_frags(400);
    close_tile(0);
    cmp_tile("R2");
    check(ext_rd(exp_addr(0)) === {24'd90, 32'hA1}, "R5", "pixel (0,0)", ext_rd(exp_addr(0)), {24'd90, 32'hA1});
    check(ext_rd(exp_addr(2)) === {24'd200, 32'hD2}, "R5", "pixel (2,0)", ext_rd(exp_addr(2)), {24'd200, 32'hD2});
    check(ext_rd(exp_addr(N - 1)) === {CLR_D, CLR_C}, "R4", "pixel (31,31)", ext_rd(exp_addr(N - 1)), {CLR_D, CLR_C});
    check(ext_rd(exp_addr(3 * TILE + 5)) === {24'd50, 32'hC0}, "R4", "pixel (5,3)", ext_rd(exp_addr(3 * TILE + 5)), {24'd50, 32'hC0});
    check(ext_rd(exp_addr(4 * TILE)) === {CLR_D, CLR_C}, "R2", "untouched pixel", ext_rd(exp_addr(4 * TILE)), {CLR_D, CLR_C});

    // tile (1,0) loaded from prior pattern
    do_start(1, 0, 1);
    while (!frag_ready) @(negedge clk);
    check(rd_acc == N, "R3", "load read count", rd_acc, N);
    check(rd_bad == 0, "R3", "load address order", rd_bad, 0);
    rand_frags(300);
    close_tile(0);
    cmp_tile("R3");

    // tile (0,0) reloaded
    do_start(0, 0, 1);
    while (!frag_ready) @(negedge clk);
    rand_frags(300);
    close_tile(1);
    cmp_tile("R4");

    // R9: flush while loading tile (0,1)
    do_start(0, 1, 1);
    rc = ready_cycles;
    repeat (5) @(negedge clk);
    flush = 1; @(negedge clk); flush = 0;
    wait_store();
    check(rd_acc == N, "R9", "load completed before store", rd_acc, N);
    check(ready_cycles == rc, "R9", "ready cycles during flushed load", ready_cycles - rc, 0);
    cmp_tile("R9");

    // R9: flush while clearing tile (1,1)
    do_start(1, 1, 0);
    rc = ready_cycles;
    repeat (3) @(negedge clk);
    flush = 1; @(negedge clk); flush = 0;
    wait_store();
    check(ready_cycles == rc, "R9", "ready cycles during flushed clear", ready_cycles - rc, 0);
    cmp_tile("R9");

    check(ready_bus_bad == 0, "R7", "ready with bus request", ready_bus_bad, 0);
    check(hold_bad == 0, "R10", "request held under backpressure", hold_bad, 0);
    report();
  end
endmodule